// File: doc/BRIEF.md
# Instrument status LED controller

This block drives the two bicolor front-panel indicators of one 16-channel instrument group. The power/fault indicator lights green while supply conditions are healthy and red while a power-on fault is flagged. The access/error indicator stays dark when the group is idle, blinks green while bus transfers or command/query operations take place, and turns solid red once an unrecognized command or data error is reported. Red stays on until the error is cleared.

Activity events arrive as single-cycle pulses. A programmable hold window stretches each pulse so that a single short transfer still produces a visible blink. The blink comes from a free-running prescaler, so every indicator in a chassis blinks at the same rate. Each indicator has a red enable and a green enable, and the block never asserts both at once.

Top module: `status_led_ctrl`

## Requirements
- R1: One cycle after `pwr_good_i` is high and `pwr_fault_i` is low at a clock edge, `fault_grn_o` is 1 and `fault_red_o` is 0. If both flags are low, both fault outputs are 0.
- R2: One cycle after `pwr_fault_i` is high at a clock edge, `fault_red_o` is 1 and `fault_grn_o` is 0, whatever the value of `pwr_good_i`.
- R3: While activity is held and no error is latched, `acc_grn_o` follows the blink phase: it is 1 in odd half-periods and 0 in even half-periods. `acc_red_o` is 0.
- R4: A pulse on `err_i` latches the error state at the next edge. From then on `acc_red_o` is 1 and `acc_grn_o` is 0, even while activity continues.
- R5: With no error latched and no activity held, both access outputs are 0.
- R6: A pulse on `xfer_i` or `cmd_i` holds activity for exactly HOLD_CYCLES cycles after the edge that samples it. A new pulse restarts the window.
- R7: `err_clr_i` clears the latched error at the next edge. If `err_i` and `err_clr_i` are high in the same cycle, the error stays latched.
- R8: Neither indicator ever has its red and green enables high together.
- R9: The blink phase is 0 right after reset and toggles every BLINK_DIV cycles, whether or not there is activity.
- R10: While `rst_ni` is low, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Power-up conditions normal |
| pwr_fault_i | input | 1 | Power-on fault present |
| xfer_i | input | 1 | Pulse for a bus data transfer |
| cmd_i | input | 1 | Pulse for command/query activity |
| err_i | input | 1 | Pulse for an unrecognized command or data error |
| err_clr_i | input | 1 | Clears the latched error |
| fault_red_o | output | 1 | Red enable, fault indicator |
| fault_grn_o | output | 1 | Green enable, fault indicator |
| acc_red_o | output | 1 | Red enable, access indicator |
| acc_grn_o | output | 1 | Green enable, access indicator |

## Verification
The fault outputs and the error latch both respond one cycle after the edge that samples their inputs. The hold window opens on the edge after an activity pulse and lasts exactly HOLD_CYCLES cycles. The blink phase changes on every BLINK_DIV-th edge counted from reset. The bench keeps a behavioural model and advances it on the same rising edge as the design. It compares all four outputs on the following falling edge, so each expected value already includes the single register stage. Directed checks at the end of a hold window, at an error clear and at an error/clear collision are also sampled on falling edges, at cycle counts worked out from these latencies.

// File: rtl/status_led_pkg.sv
package status_led_pkg;
  typedef enum logic [1:0] {
    LED_OFF   = 2'd0,
    LED_GREEN = 2'd1,
    LED_RED   = 2'd2
  } led_color_t;

  function automatic logic is_red(led_color_t c);
    return c == LED_RED;
  endfunction

  function automatic logic is_green(led_color_t c);
    return c == LED_GREEN;
  endfunction
endpackage

// File: rtl/led_blink_div.sv
module led_blink_div #(
  parameter int unsigned BLINK_DIV = 12_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o
);
  localparam int unsigned CntW = $clog2(BLINK_DIV + 1);
  localparam logic [CntW-1:0] CntMax = CntW'(BLINK_DIV - 1);

  logic [CntW-1:0] cnt_q;
  logic            wrap;

  assign wrap = (cnt_q == CntMax);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      phase_o <= ~phase_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_phase_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(phase_o));
endmodule

// File: rtl/led_act_hold.sv
module led_act_hold #(
  parameter int unsigned HOLD_CYCLES = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic active_o
);
  localparam int unsigned HoldW = $clog2(HOLD_CYCLES + 1);
  localparam logic [HoldW-1:0] HoldLoad = HoldW'(HOLD_CYCLES);

  logic [HoldW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hold_q <= '0;
    else if (pulse_i)         hold_q <= HoldLoad;
    else if (hold_q != '0)    hold_q <= hold_q - 1'b1;
  end

  assign active_o = (hold_q != '0);

  p_hold_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> active_o);
endmodule

// File: rtl/led_err_latch.sv
module led_err_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  // set beats clear so a simultaneous error is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_o <= 1'b0;
    else if (set_i)  err_o <= 1'b1;
    else if (clr_i)  err_o <= 1'b0;
  end

  p_err_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> err_o);
  p_err_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !err_o);
endmodule

// File: rtl/status_led_ctrl.sv
module status_led_ctrl
  import status_led_pkg::*;
#(
  parameter int unsigned BLINK_DIV   = 12_500_000,
  parameter int unsigned HOLD_CYCLES = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic pwr_fault_i,
  input  logic xfer_i,
  input  logic cmd_i,
  input  logic err_i,
  input  logic err_clr_i,
  output logic fault_red_o,
  output logic fault_grn_o,
  output logic acc_red_o,
  output logic acc_grn_o
);
  logic       phase;
  logic       active;
  logic       err_q;
  led_color_t fault_col_q;
  led_color_t acc_col;

  led_blink_div #(.BLINK_DIV(BLINK_DIV)) u_blink (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(phase)
  );

  led_act_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (xfer_i | cmd_i),
    .active_o(active)
  );

  led_err_latch u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (err_i),
    .clr_i (err_clr_i),
    .err_o (err_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          fault_col_q <= LED_OFF;
    else if (pwr_fault_i) fault_col_q <= LED_RED;
    else if (pwr_good_i)  fault_col_q <= LED_GREEN;
    else                  fault_col_q <= LED_OFF;
  end

  always_comb begin
    if (err_q)                acc_col = LED_RED;
    else if (active && phase) acc_col = LED_GREEN;
    else                      acc_col = LED_OFF;
  end

  assign fault_red_o = is_red(fault_col_q);
  assign fault_grn_o = is_green(fault_col_q);
  assign acc_red_o   = is_red(acc_col);
  assign acc_grn_o   = is_green(acc_col);

  p_fault_red_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fault_i |=> (fault_red_o && !fault_grn_o));
  p_fault_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fault_red_o && fault_grn_o));
  p_acc_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_red_o && acc_grn_o));
  p_err_over_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> (acc_red_o && !acc_grn_o));
  p_idle_dark_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_q && !active) |-> (!acc_red_o && !acc_grn_o));
endmodule

// File: tb/status_led_ctrl_bench.sv
module status_led_ctrl_bench;
  localparam int DIV  = 4;
  localparam int HOLD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0, pwr_fault = 1'b0, xfer = 1'b0, cmd = 1'b0;
  logic err = 1'b0, err_clr = 1'b0;
  logic f_red, f_grn, a_red, a_grn;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // reference model state
  int m_div = 0, m_hold = 0;
  bit m_ph = 0, m_err = 0, m_fr = 0, m_fg = 0;

  always #5 clk = ~clk;

  status_led_ctrl #(.BLINK_DIV(DIV), .HOLD_CYCLES(HOLD)) u_status_led_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .pwr_good_i(pwr_good), .pwr_fault_i(pwr_fault),
    .xfer_i(xfer), .cmd_i(cmd), .err_i(err), .err_clr_i(err_clr),
    .fault_red_o(f_red), .fault_grn_o(f_grn),
    .acc_red_o(a_red), .acc_grn_o(a_grn)
  );

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: got %b expected %b", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_hold = 0; m_ph = 0; m_err = 0; m_fr = 0; m_fg = 0;
    end else begin
      cyc++;
      m_fr = pwr_fault;
      m_fg = pwr_good && !pwr_fault;
      if (err) m_err = 1;
      else if (err_clr) m_err = 0;
      if (xfer || cmd) m_hold = HOLD;
      else if (m_hold > 0) m_hold--;
      if (m_div == DIV - 1) begin m_div = 0; m_ph = !m_ph; end
      else m_div++;
    end
  end

  // per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      check("R10 fault_red", f_red, 1'b0);
      check("R10 fault_grn", f_grn, 1'b0);
      check("R10 acc_red", a_red, 1'b0);
      check("R10 acc_grn", a_grn, 1'b0);
    end else begin
      check("R1 R2 fault_grn", f_grn, m_fg);
      check("R2 fault_red", f_red, m_fr);
      check("R4 R7 acc_red", a_red, m_err);
      check("R3 R5 R6 R9 acc_grn", a_grn, !m_err && m_hold > 0 && m_ph);
      check("R8 fault exclusive", f_red && f_grn, 1'b0);
      check("R8 acc exclusive", a_red && a_grn, 1'b0);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    pwr_good = 1'b1;
    idle(10);
    check("R1 idle green", f_grn, 1'b1);
    check("R5 idle dark", a_red | a_grn, 1'b0);
    pulse(xfer);
    // window of HOLD cycles after the sampling edge, then dark
    idle(HOLD);
    check("R6 window closed", a_grn, 1'b0);
    idle(5);
    pulse(cmd);
    idle(10);
    pulse(xfer);
    idle(15);
    pulse(xfer); pulse(cmd);
    idle(8);
    @(negedge clk) pwr_fault = 1'b1;
    idle(5);
    check("R2 fault red", f_red, 1'b1);
    pwr_fault = 1'b0;
    pulse(xfer);
    idle(3);
    pulse(err);
    check("R4 error red", a_red, 1'b1);
    pulse(xfer);
    idle(12);
    pulse(err_clr);
    check("R7 cleared", a_red, 1'b0);
    pulse(cmd);
    @(negedge clk) begin err = 1'b1; err_clr = 1'b1; end
    @(negedge clk) begin err = 1'b0; err_clr = 1'b0; end
    check("R7 set beats clear", a_red, 1'b1);
    idle(6);
    pulse(err_clr);
    pwr_good = 1'b0;
    idle(3);
    check("R1 no power dark", f_grn | f_red, 1'b0);
    idle(30);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R10: got hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule